// File: doc/BRIEF.md
# Software-Serviced Watchdog Reset Timer

This block catches a processor that has stopped running its program correctly. While it is enabled, it counts prescaled clock ticks. If software does not restart the count with a kick strobe before the selected period runs out, the block raises a one-cycle reset request for the system reset logic. A sticky cause flag records that the watchdog produced the reset. Software can read the flag after the restart and clear it with a dedicated input.

Software sets the watchdog up through a small control write port. The port carries an unlock bit, a run bit and a 3-bit period code. Any write can switch the watchdog on. Switching it off or changing its period needs a two-step sequence. First, a write with both unlock and run set opens a short unlock window. A second write inside that window is then allowed to clear run or load a new period code. The window shuts after that one write, or after `UNLOCK_WIN` cycles, whichever comes first.

A period code k gives a timeout of `PRESCALE * 2^(BASE_EXP+k)` clock cycles. The hardware default is `BASE_EXP` = 14. A small base keeps simulation short.

Top module: `wdog_guard`

## Requirements
- R1: After power-on reset (`rst_n` low), the outputs read as follows: run is 0, period code is 0, cause flag is 0, and no reset request.
- R2: While running with period code k and no restart, `wd_rst_req` is high for exactly one cycle. That cycle is `PRESCALE*2^(BASE_EXP+k)` cycles after the last restart edge.
- R3: A kick strobe restarts the timeout from zero, both the prescaler and the tick count.
- R4: While run is 0, no reset request is raised and the count is held at zero.
- R5: Any write with the run bit at 1 sets run, whether or not the unlock window is open.
- R6: A write with both unlock and run at 1 opens the unlock window. A write inside the window may clear run or load `cfg_sel`. A write outside the window leaves run set and the period code unchanged.
- R7: The window lets through writes only in the `UNLOCK_WIN` (default 4) cycles after the opening write. Any write made inside the window closes it.
- R8: A write accepted inside the window restarts the timeout from zero, even if the period code it loads is unchanged.
- R9: After a timeout the count restarts from zero, run stays 1, and the requests repeat every period.
- R10: `wd_cause` goes high on the cycle the request goes high. It stays high until `cause_clr` or power-on reset clears it. If a timeout and a clear fall on the same edge, the set wins.
- R11: A kick on the same edge at which the period would end suppresses the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| cfg_wr | input | 1 | Control write strobe |
| cfg_unlock | input | 1 | Unlock bit of the control write |
| cfg_run | input | 1 | Run (enable) bit of the control write |
| cfg_sel | input | 3 | Period code of the control write |
| kick | input | 1 | Restart strobe from software |
| cause_clr | input | 1 | Clears the watchdog cause flag |
| wd_rst_req | output | 1 | One-cycle system reset request |
| wd_cause | output | 1 | Sticky flag: watchdog caused a reset |
| cfg_run_q | output | 1 | Current run state, for read-back |
| cfg_sel_q | output | 3 | Current period code, for read-back |

## Verification
The timeout is driven in several ways, each against a model that tracks the cycles elapsed since the last restart:
- Left free-running at the shortest and the longest period code, which confirms the period arithmetic and the one-cycle pulse width.
- Kicked well inside the period, and kicked on the exact edge of expiry, which separates a correct restart from an off-by-one comparison.
- Written with accepted period changes, which confirms the restart that such a write causes.

The protected writes are tried at the last cycle inside the unlock window and the first cycle after it. A second write inside one window checks that the window closes after one use. A clear held through an expiry shows whether the set takes priority over the clear.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
  localparam int unsigned SEL_W = 3;
  typedef logic [SEL_W-1:0] wdg_sel_t;

  // Index of the last tick of a period: 2^(base+sel) - 1
  function automatic int unsigned wdg_last_tick(int unsigned base, wdg_sel_t sel);
    return (32'd1 << (base + 32'(sel))) - 32'd1;
  endfunction
endpackage

// File: rtl/wdg_prescaler.sv
`timescale 1ns/1ps
module wdg_prescaler #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE <= 1) begin : g_bypass
      logic unused_ok;
      assign unused_ok = clr ^ rst_n ^ clk;
      assign tick = 1'b1;
    end else begin : g_div
      logic [PW-1:0] pre_q;
      logic          wrap;
      assign wrap = (pre_q == PW'(PRESCALE - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pre_q <= '0;
        else if (clr || wrap)  pre_q <= '0;
        else                   pre_q <= pre_q + PW'(1);
      end
      assign tick = wrap && !clr;

      AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PW'(PRESCALE - 1)); // R2
      AST_PRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0)); // R3
    end
  endgenerate
endmodule

// File: rtl/wdg_ctrl.sv
`timescale 1ns/1ps
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int unsigned UNLOCK_WIN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  logic     unlock,
  input  logic     run,
  input  wdg_sel_t sel_in,
  output logic     en_q,
  output wdg_sel_t sel_q,
  output logic     win_open,
  output logic     sel_accept
);
  localparam int unsigned WW = $clog2(UNLOCK_WIN + 1);

  logic [WW-1:0] win_q;
  logic          arm;

  assign arm        = wr && unlock && run;
  assign win_open   = (win_q != '0);
  assign sel_accept = wr && win_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
      win_q <= '0;
    end else if (wr) begin
      if (run)           en_q <= 1'b1;
      else if (win_open) en_q <= 1'b0;
      if (win_open)      sel_q <= sel_in;
      win_q <= arm ? WW'(UNLOCK_WIN) : '0;
    end else if (win_open) begin
      win_q <= win_q - WW'(1);
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= WW'(UNLOCK_WIN)); // R7
  AST_LOCKED_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !run && !win_open) |=> (en_q == $past(en_q))); // R6
  AST_LOCKED_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !win_open) |=> (sel_q == $past(sel_q))); // R6
  AST_RUN_SET_ANYTIME: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && run) |=> en_q); // R5
  AST_WIN_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !arm) |=> !win_open); // R7
endmodule

// File: rtl/wdg_counter.sv
`timescale 1ns/1ps
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int unsigned BASE_EXP = 14
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  wdg_sel_t sel,
  input  logic     tick,
  input  logic     restart,
  output logic     expire
);
  localparam int unsigned CW = BASE_EXP + 8;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = CW'(wdg_last_tick(BASE_EXP, sel));
  assign expire = en && tick && !restart && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart || expire) cnt_q <= '0;
    else if (tick)              cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last); // R2
  AST_CNT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/wdog_guard.sv
`timescale 1ns/1ps
module wdog_guard
  import wdg_pkg::*;
#(
  parameter int unsigned PRESCALE   = 4,
  parameter int unsigned BASE_EXP   = 14,
  parameter int unsigned UNLOCK_WIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       cfg_unlock,
  input  logic       cfg_run,
  input  logic [2:0] cfg_sel,
  input  logic       kick,
  input  logic       cause_clr,
  output logic       wd_rst_req,
  output logic       wd_cause,
  output logic       cfg_run_q,
  output logic [2:0] cfg_sel_q
);
  // named internal events
  logic     en;
  wdg_sel_t sel;
  logic     win_open;
  logic     sel_accept;
  logic     restart;
  logic     tick;
  logic     expire;

  wdg_ctrl #(.UNLOCK_WIN(UNLOCK_WIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .unlock(cfg_unlock),
    .run(cfg_run), .sel_in(cfg_sel), .en_q(en), .sel_q(sel),
    .win_open(win_open), .sel_accept(sel_accept)
  );

  assign restart = kick || sel_accept || !en;

  wdg_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(restart), .tick(tick)
  );

  wdg_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .sel(sel), .tick(tick),
    .restart(restart), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_rst_req <= 1'b0;
      wd_cause   <= 1'b0;
    end else begin
      wd_rst_req <= expire;
      if (expire)         wd_cause <= 1'b1;
      else if (cause_clr) wd_cause <= 1'b0;
    end
  end

  assign cfg_run_q = en;
  assign cfg_sel_q = sel;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |=> !wd_rst_req); // R2
  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !wd_rst_req); // R4
  AST_KICK_SUPPRESSES: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !wd_rst_req); // R11
  AST_ACCEPT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    sel_accept |=> !wd_rst_req); // R8
  AST_CAUSE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |-> wd_cause); // R10
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_cause && !cause_clr) |=> wd_cause); // R10
  AST_CAUSE_ONLY_BY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_cause) |-> wd_rst_req); // R10
endmodule

// File: tb/test_wdog_guard.sv
`timescale 1ns/1ps
module test_wdog_guard;
  localparam int P = 2;
  localparam int B = 3;
  localparam int W = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_unlock = 1'b0, cfg_run = 1'b0;
  logic [2:0] cfg_sel = 3'd0;
  logic       kick = 1'b0, cause_clr = 1'b0;
  logic       wd_rst_req, wd_cause, cfg_run_q;
  logic [2:0] cfg_sel_q;

  int  total = 0;
  int  bad = 0;
  int  pulses = 0;
  int  p0;
  bit  done = 0;

  // behavioural reference state
  int m_en, m_sel, m_win, m_age, m_req, m_flag;

  always #5 clk = ~clk;

  wdog_guard #(.PRESCALE(P), .BASE_EXP(B), .UNLOCK_WIN(W)) i_wdog_guard (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_unlock(cfg_unlock),
    .cfg_run(cfg_run), .cfg_sel(cfg_sel), .kick(kick), .cause_clr(cause_clr),
    .wd_rst_req(wd_rst_req), .wd_cause(wd_cause),
    .cfg_run_q(cfg_run_q), .cfg_sel_q(cfg_sel_q)
  );

  function automatic int period(int s);
    return P * (1 << (B + s));
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model, advanced at every edge, compared 2 ns later
  always @(posedge clk) begin : model
    bit wo, sok, rs, ex;
    if (!rst_n) begin
      m_en = 0; m_sel = 0; m_win = 0; m_age = 0; m_req = 0; m_flag = 0;
    end else begin
      wo  = (m_win > 0);
      sok = cfg_wr && wo;
      rs  = kick || sok || (m_en == 0);
      ex  = (m_en != 0) && !rs && (m_age == period(m_sel) - 1);
      m_req  = ex ? 1 : 0;
      m_flag = ex ? 1 : (cause_clr ? 0 : m_flag);
      m_age  = (rs || ex) ? 0 : m_age + 1;
      if (cfg_wr) begin
        if (cfg_run) m_en = 1;
        else if (wo) m_en = 0;
        if (wo) m_sel = int'(cfg_sel);
        m_win = (cfg_unlock && cfg_run) ? W : 0;
      end else if (wo) begin
        m_win--;
      end
    end
    #2;
    if (rst_n && !done) begin
      chk("R2 request vs model", int'(wd_rst_req), m_req);
      chk("R10 cause flag vs model", int'(wd_cause), m_flag);
      chk("R5 run state vs model", int'(cfg_run_q), m_en);
      chk("R6 period code vs model", int'(cfg_sel_q), m_sel);
    end
  end

  task automatic step(bit w, bit u, bit r, int s, bit k, bit c);
    @(negedge clk);
    if (wd_rst_req) pulses++;
    cfg_wr = w; cfg_unlock = u; cfg_run = r; cfg_sel = 3'(s);
    kick = k; cause_clr = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset request", int'(wd_rst_req), 0);
    chk("R1 reset cause", int'(wd_cause), 0);
    chk("R1 reset run", int'(cfg_run_q), 0);
    chk("R1 reset period", int'(cfg_sel_q), 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 idle after reset", int'(cfg_run_q), 0);

    // R5 / R6: plain write enables, period stays locked
    step(1, 0, 1, 5, 0, 0); idle(1);
    chk("R5 run set without unlock", int'(cfg_run_q), 1);
    chk("R6 period locked", int'(cfg_sel_q), 0);

    // R2: free running at code 0 (16 cycles)
    p0 = pulses; idle(40);
    chk("R2 pulses at shortest period", pulses - p0, 2);
    chk("R10 cause set by timeout", int'(wd_cause), 1);

    // R10: clear (with kick to keep timing clear)
    step(0, 0, 0, 0, 1, 1); idle(1);
    chk("R10 cause cleared", int'(wd_cause), 0);

    // R3: regular kicks
    p0 = pulses;
    for (int j = 0; j < 6; j++) begin step(0, 0, 0, 0, 1, 0); idle(9); end
    chk("R3 kicks prevent request", pulses - p0, 0);

    // R11: kick on the expiry edge
    p0 = pulses;
    step(0, 0, 0, 0, 1, 0); idle(15); step(0, 0, 0, 0, 1, 0); idle(5);
    chk("R11 kick at expiry edge", pulses - p0, 0);

    // R6: locked clear ignored
    step(1, 0, 0, 0, 0, 0); idle(1);
    chk("R6 locked clear ignored", int'(cfg_run_q), 1);

    // R7: write one cycle after the window
    step(0, 0, 0, 0, 1, 0);
    step(1, 1, 1, 0, 0, 0); idle(4); step(1, 0, 0, 3, 0, 0); idle(1);
    chk("R7 late clear ignored", int'(cfg_run_q), 1);
    chk("R7 late period ignored", int'(cfg_sel_q), 0);

    // R6: clear on the last cycle of the window, then R4
    step(0, 0, 0, 0, 1, 0);
    step(1, 1, 1, 0, 0, 0); idle(3); step(1, 0, 0, 0, 0, 0); idle(1);
    chk("R6 unlocked clear", int'(cfg_run_q), 0);
    p0 = pulses; idle(100);
    chk("R4 no request while off", pulses - p0, 0);

    // R8: accepted write restarts even with the same code
    step(1, 0, 1, 0, 0, 0); idle(10);
    step(1, 1, 1, 0, 0, 0); step(1, 0, 1, 0, 0, 0);
    p0 = pulses; idle(14);
    chk("R8 accepted write restarted count", pulses - p0, 0);
    p0 = pulses; idle(4);
    chk("R8 request one period after restart", pulses - p0, 1);

    // R7: window closes after one write
    step(1, 1, 1, 0, 0, 0); step(1, 0, 1, 2, 0, 0); step(1, 0, 1, 4, 0, 0); idle(1);
    chk("R7 second write in window ignored", int'(cfg_sel_q), 2);

    // R9: repeats at code 2 (64 cycles), stays enabled
    p0 = pulses; idle(140);
    chk("R9 repeated requests", pulses - p0, 2);
    chk("R9 still enabled", int'(cfg_run_q), 1);

    // R10: set wins over a clear held through the expiry edge
    step(0, 0, 0, 0, 1, 0);
    for (int j = 0; j < 64; j++) step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R10 request at expiry", int'(wd_rst_req), 1);
    chk("R10 set wins over clear", int'(wd_cause), 1);
    idle(1);
    chk("R10 flag sticky", int'(wd_cause), 1);

    // R2: longest period, code 7 (2048 cycles)
    step(1, 1, 1, 0, 0, 0); step(1, 0, 1, 7, 0, 0);
    p0 = pulses; idle(2100);
    chk("R2 pulse at longest period", pulses - p0, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule